// File: doc/BRIEF.md
# Prefetch Accuracy Gate

This block watches a prefetcher at run time and decides whether its prefetches deserve cheap treatment by the DRAM scheduler. It counts two event streams: one strobe per prefetch handed to memory, and one strobe each time a demand access first touches a line that still carries its prefetched mark. The mark itself lives in the cache. This block sees it only through that second strobe.

The issue counter is a 10-bit wrapping counter. Every time it rolls over, the block takes the number of useful prefetches from the window that just closed. It compares that number against a threshold given as a whole percentage. While the measured accuracy is at or above the threshold, the enable output lets the scheduler issue prefetches into rows that are already open. When accuracy falls below the threshold, the enable drops and the scheduler sends prefetches only when the bus is idle. The comparison uses no divider. The percentage is scaled once to a count out of 1024, and that count is compared with the sample.

Top module: `pf_accuracy_gate`

## Requirements
- R1: After reset, `piggy_en` is 1 and `acc_sample` is 0.
- R2: Each cycle with `issue_stb` high advances a 10-bit issue count. The 1024th issue since the last rollover is a rollover cycle. Both outputs update on the clock edge that ends a rollover cycle, and they hold their values on every other edge, including during issue gaps.
- R3: Each cycle with `useful_stb` high adds one to the useful count, which saturates at 1023 and never wraps.
- R4: At a rollover, `acc_sample` takes the useful count accumulated before that cycle. The useful count then restarts: a useful strobe in the rollover cycle itself leaves the new window at 1, and otherwise it is 0.
- R5: At a rollover, `piggy_en` becomes 1 when the sample is greater than or equal to floor(`thr_pct` × 1024 / 100), and 0 otherwise. `thr_pct` is an unsigned whole percentage. With 38 the bound is 389.
- R6: A `thr_pct` of 0 makes every rollover set `piggy_en` to 1. A `thr_pct` of 100 or more makes every rollover clear it, because the bound reaches at least 1024.
- R7: An issue strobe and a useful strobe in the same cycle are both counted.
- R8: `thr_pct` is read only in a rollover cycle. Changing it between rollovers leaves both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_stb | input | 1 | One prefetch issued this cycle |
| useful_stb | input | 1 | First demand hit on a prefetched line this cycle |
| thr_pct | input | 7 | Accuracy threshold in percent |
| piggy_en | output | 1 | 1: piggyback prefetches on open rows; 0: idle-bus only |
| acc_sample | output | 10 | Useful count from the last closed window |

## Verification
The rollover of the issue count and an arriving useful strobe can land in the same cycle. That collision decides which window the strobe belongs to. The bench forces it by raising `useful_stb` exactly on the 1024th issue. It judges the result from the following sample, which must read 1 after an otherwise empty window. The bench also drives both strobes together across whole windows, and it moves the threshold between rollovers, checking the outputs every cycle against a scoreboard model.

// File: rtl/pfag_pkg.sv
package pfag_pkg;
    // default geometry of the accuracy window
    localparam int DEF_CNT_W = 10;
    localparam int DEF_PCT_W = 7;
    localparam int PCT_FULL  = 100;
endpackage

// File: rtl/pfag_issue_ctr.sv
module pfag_issue_ctr #(
    parameter int CNT_W = pfag_pkg::DEF_CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_stb,
    output logic wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (issue_stb) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        wrap = issue_stb && (st_q.cnt == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a rollover leaves the window count at zero
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> st_q.cnt == '0);

    // no issue, no movement
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_stb |=> $stable(st_q.cnt));
endmodule

// File: rtl/pfag_useful_ctr.sv
module pfag_useful_ctr #(
    parameter int CNT_W = pfag_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             useful_stb,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            // a strobe in the sampling cycle opens the new window
            st_d.cnt = useful_stb ? CNT_W'(1) : '0;
        end else if (useful_stb && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) && !clr |=> cnt == CNT_MAX);

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt <= CNT_W'(1));
endmodule

// File: rtl/pfag_thr_scale.sv
module pfag_thr_scale #(
    parameter int CNT_W = pfag_pkg::DEF_CNT_W,
    parameter int PCT_W = pfag_pkg::DEF_PCT_W
) (
    input  logic [PCT_W-1:0] thr_pct,
    output logic [CNT_W:0]   bound
);
    localparam int PROD_W = PCT_W + CNT_W;
    localparam logic [PROD_W-1:0] FULL = PROD_W'(1) << CNT_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        prod = {thr_pct, {CNT_W{1'b0}}};
        quot = prod / PROD_W'(pfag_pkg::PCT_FULL);
        // anything above a full window can never be met
        bound = (quot > FULL) ? FULL[CNT_W:0] : quot[CNT_W:0];
    end
endmodule

// File: rtl/pf_accuracy_gate.sv
module pf_accuracy_gate #(
    parameter int CNT_W = pfag_pkg::DEF_CNT_W,
    parameter int PCT_W = pfag_pkg::DEF_PCT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_stb,
    input  logic             useful_stb,
    input  logic [PCT_W-1:0] thr_pct,
    output logic             piggy_en,
    output logic [CNT_W-1:0] acc_sample
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] sample;
    } st_t;

    st_t              st_d, st_q;
    logic             wrap;
    logic [CNT_W-1:0] useful_cnt;
    logic [CNT_W:0]   bound;

    pfag_issue_ctr #(.CNT_W(CNT_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_stb (issue_stb),
        .wrap      (wrap)
    );

    pfag_useful_ctr #(.CNT_W(CNT_W)) u_useful (
        .clk        (clk),
        .rst_n      (rst_n),
        .useful_stb (useful_stb),
        .clr        (wrap),
        .cnt        (useful_cnt)
    );

    pfag_thr_scale #(.CNT_W(CNT_W), .PCT_W(PCT_W)) u_scale (
        .thr_pct (thr_pct),
        .bound   (bound)
    );

    always_comb begin
        st_d = st_q;
        if (wrap) begin
            st_d.sample = useful_cnt;
            st_d.en     = ({1'b0, useful_cnt} >= bound);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en     <= 1'b1;
            st_q.sample <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign piggy_en   = st_q.en;
    assign acc_sample = st_q.sample;

    p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(piggy_en) && $stable(acc_sample));

    p_sample_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> acc_sample == $past(useful_cnt));

    p_zero_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && (thr_pct == '0) |=> piggy_en);

    p_full_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && (thr_pct >= PCT_W'(pfag_pkg::PCT_FULL)) |=> !piggy_en);

    p_both_counted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stb && useful_stb && !wrap && (useful_cnt != CNT_MAX)
        |=> useful_cnt == $past(useful_cnt) + 1'b1);
endmodule

// File: tb/test_pf_accuracy_gate.sv
module test_pf_accuracy_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_stb = 1'b0;
    logic       useful_stb = 1'b0;
    logic [6:0] thr_pct = 7'd38;
    logic       piggy_en;
    logic [9:0] acc_sample;

    always #4 clk = ~clk;

    pf_accuracy_gate i_pf_accuracy_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_stb  (issue_stb),
        .useful_stb (useful_stb),
        .thr_pct    (thr_pct),
        .piggy_en   (piggy_en),
        .acc_sample (acc_sample)
    );

    typedef struct {
        bit    en;
        int    samp;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    n_vec = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    // reference model state
    int m_iss = 0;
    int m_use = 0;
    int m_samp = 0;
    bit m_en = 1'b1;

    task automatic chk(input bit en, input int samp, input string tag);
        n_vec++;
        if (piggy_en !== en || int'(acc_sample) != samp) begin
            n_bad++;
            $display("FAIL %s: piggy_en=%0b acc_sample=%0d expected piggy_en=%0b acc_sample=%0d",
                     tag, piggy_en, acc_sample, en, samp);
        end
    endtask

    task automatic step(input bit iss, input bit use_s);
        exp_t e;
        int   bnd;
        @(negedge clk);
        issue_stb  = iss;
        useful_stb = use_s;
        @(posedge clk);
        #1;
        if (iss && m_iss == 1023) begin
            bnd = (int'(thr_pct) * 1024) / 100;
            if (bnd > 1024) bnd = 1024;
            m_samp = m_use;
            m_en   = (m_samp >= bnd);
            m_use  = use_s ? 1 : 0;
        end else if (use_s && m_use < 1023) begin
            m_use++;
        end
        if (iss) m_iss = (m_iss + 1) % 1024;
        e.en = m_en; e.samp = m_samp; e.tag = cur_tag;
        sb.push_back(e);
    endtask

    // 1024 issues, useful on the first k, optional useful on the rollover cycle
    task automatic window(input int k, input bit use_last);
        for (int i = 0; i < 1024; i++)
            step(1'b1, (i < k) || (i == 1023 && use_last));
    endtask

    // monitor: compare every produced cycle against the scoreboard
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.en, e.samp, e.tag);
        end
    end

    bit done = 1'b0;
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: run incomplete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(1'b1, 0, "R1");                // reset state
        cur_tag = "R2"; repeat (20) step(1'b0, 1'b0);
        // R5: bound 389 at 38 percent
        cur_tag = "R5"; window(400, 1'b0);  // above -> 1
        cur_tag = "R5"; window(388, 1'b0);  // just below -> 0
        cur_tag = "R5"; window(389, 1'b0);  // exactly at -> 1
        // R4: strobe on the rollover cycle belongs to the new window
        cur_tag = "R4"; window(10, 1'b1);
        cur_tag = "R4"; window(0, 1'b0);    // sample 1
        // R7: both strobes together for 600 cycles
        cur_tag = "R7"; window(600, 1'b0);
        // R2: issue gaps, outputs hold until the 1024th issue
        cur_tag = "R2";
        for (int i = 0; i < 2048; i++) step(i % 2 == 0, i < 900);
        // R8: threshold moved between rollovers
        cur_tag = "R8";
        for (int i = 0; i < 1024; i++) begin
            if (i == 300) thr_pct = 7'd0;
            if (i == 800) thr_pct = 7'd38;
            step(1'b1, i < 200);
        end
        // R3: saturation without issues
        cur_tag = "R3";
        for (int i = 0; i < 1500; i++) step(1'b0, 1'b1);
        thr_pct = 7'd100;
        cur_tag = "R6"; window(0, 1'b0);    // sample 1023, full threshold -> 0
        thr_pct = 7'd0;
        cur_tag = "R6"; window(0, 1'b0);    // sample 0, zero threshold -> 1
        thr_pct = 7'd127;
        cur_tag = "R6"; window(1024, 1'b0); // over 100 percent -> 0
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule